// File: doc/BRIEF.md
# DRAM Refresh and Wake-Up Scheduler

This block owns the refresh duty of an asynchronous DRAM that has an internal row counter. After reset it stays silent for a power-on pause. It then wins the memory bus from the access controller and runs a burst of wake-up strobe cycles. Only after that burst does it declare the memory usable. From then on, a periodic timer marks when each refresh falls due. The block asks for the bus, waits for a grant, and runs one column-first refresh strobe cycle for each refresh that is owed.

The refresh period is derived from three parameters: the clock frequency in MHz, the number of rows, and the retention time in microseconds. Strobe phase lengths are given in clock cycles. While the bus is busy, owed refreshes pile up in a saturating counter. Reaching the limit raises an urgent flag. If one more refresh falls due on top of a full counter, the retention deadline counts as missed. The block then withdraws its ready indication, re-runs the full wake-up burst, and discards the owed refreshes.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted, `ras_n` and `cas_n` are high and `bus_req`, `ref_busy`, `ready` and `urgent` are low.
- R2: After reset is released, `bus_req` and both strobes stay inactive for at least CLK_MHZ*PAUSE_US cycles, and `bus_req` rises no more than four cycles after that.
- R3: After the pause, exactly WAKE_N strobe cycles (falling edges of `ras_n`) occur before `ready` first goes high.
- R4: In every strobe cycle, `cas_n` is low for at least CAS_SETUP_CYC cycles before `ras_n` falls. It stays low for exactly CAS_HOLD_CYC cycles of the row-low phase and returns high before `ras_n` rises.
- R5: `ras_n` stays low for at least RAS_LOW_CYC cycles and high for at least RAS_PRE_CYC cycles between strobe cycles.
- R6: Either strobe is low only while `ref_busy` is high. `ref_busy` rises only in the cycle after one in which `bus_req` and `bus_gnt` were both high.
- R7: While `ready` is high, one refresh falls due every CLK_MHZ*RETAIN_US/ROWS cycles. With the grant given promptly, `ready` stays high and one strobe cycle is run for each refresh that falls due.
- R8: With the grant withheld, up to MAX_OWED owed refreshes are kept. `urgent` is high exactly when the owed count equals MAX_OWED. Once the grant arrives, exactly that many strobe cycles run and then `bus_req` drops.
- R9: A refresh falling due while MAX_OWED are already owed, with none finishing in that cycle, drops `ready`. The block then re-requests the bus, runs exactly WAKE_N strobe cycles, clears the owed count (`urgent` low), and raises `ready` again.
- R10: `bus_req` stays high in every cycle where `ref_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_gnt | input | 1 | Access controller grants the strobes to this block |
| bus_req | output | 1 | Request for the strobes |
| ref_busy | output | 1 | This block is driving the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| ready | output | 1 | Memory initialized and within its retention deadline |
| urgent | output | 1 | Owed refresh count at its limit |

## Verification
Two events can land in the same cycle. The first is the timer marking a new refresh as due. The second is the completion of a strobe cycle, which retires an owed refresh. When the counter is full, those two together must leave the count unchanged and must not be taken as a missed deadline. The bench lets the owed count fill, then releases the grant at a swept set of offsets just before the next due point, so that a strobe cycle ends near or on that point. Each offset is judged by whether the block settles back to ready with nothing owed and no malformed strobe cycle. Separate directed phases check the exact strobe counts for deferral and for the re-wake-up.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [2:0] {
    CT_PAUSE,
    CT_WREQ,
    CT_WAKE,
    CT_IDLE,
    CT_REF
  } ctl_st_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_HOLD,
    SQ_LOW,
    SQ_PRE
  } seq_st_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned span);
    return (span < 2) ? 1 : $clog2(span);
  endfunction

endpackage

// File: rtl/rfsh_tick_timer.sv
module rfsh_tick_timer #(
  parameter int unsigned PERIOD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = dram_rfsh_pkg::cnt_width(PERIOD);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          at_end;
  logic          cnt_en;

  assign at_end = (cnt_q == CW'(PERIOD - 1));
  assign tick   = run && at_end;
  assign cnt_en = run || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || at_end) cnt_d = '0;
    else                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rfsh_owed_counter.sv
module rfsh_owed_counter #(
  parameter int unsigned MAX_OWED = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  input  logic clr,
  output logic full,
  output logic nonzero,
  output logic overflow
);
  localparam int unsigned CW = $clog2(MAX_OWED + 1);

  logic [CW-1:0] owed_q;
  logic [CW-1:0] owed_d;
  logic          owed_en;

  assign full     = (owed_q == CW'(MAX_OWED));
  assign nonzero  = (owed_q != '0);
  assign overflow = inc && full && !dec;

  always_comb begin
    owed_d = owed_q;
    if (clr) begin
      owed_d = '0;
    end else begin
      unique case ({inc, dec})
        2'b10:   if (!full)   owed_d = owed_q + 1'b1;
        2'b01:   if (nonzero) owed_d = owed_q - 1'b1;
        default: owed_d = owed_q;
      endcase
    end
  end

  assign owed_en = clr || (inc != dec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       owed_q <= '0;
    else if (owed_en) owed_q <= owed_d;
  end
endmodule

// File: rtl/cbr_strobe_seq.sv
module cbr_strobe_seq
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 2,
  parameter int unsigned HOLD_CYC  = 2,
  parameter int unsigned LOW_CYC   = 13,
  parameter int unsigned PRE_CYC   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic idle,
  output logic done,
  output logic ras_n,
  output logic cas_n
);
  localparam int unsigned TAIL = LOW_CYC - HOLD_CYC;
  localparam int unsigned SPAN = umax(umax(SETUP_CYC, HOLD_CYC), umax(TAIL, PRE_CYC));
  localparam int unsigned CW   = $clog2(SPAN + 1);

  seq_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last;
  logic          ras_d, cas_d;

  assign last = (cnt_q == '0);
  assign idle = (st_q == SQ_IDLE);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    done  = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (start) begin
          st_d  = SQ_SETUP;
          cnt_d = CW'(SETUP_CYC - 1);
        end
      end
      SQ_SETUP: begin
        if (last) begin
          st_d  = SQ_HOLD;
          cnt_d = CW'(HOLD_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      SQ_HOLD: begin
        if (last) begin
          st_d  = SQ_LOW;
          cnt_d = CW'(TAIL - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      SQ_LOW: begin
        if (last) begin
          st_d  = SQ_PRE;
          cnt_d = CW'(PRE_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      SQ_PRE: begin
        if (last) begin
          st_d = SQ_IDLE;
          done = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  // Strobe levels decoded from the next state and registered, so the pins
  // follow the current phase without decode glitches.
  assign ras_d = !((st_d == SQ_HOLD) || (st_d == SQ_LOW));
  assign cas_d = !((st_d == SQ_SETUP) || (st_d == SQ_HOLD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      ras_n <= ras_d;
      cas_n <= cas_d;
    end
  end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned CLK_MHZ       = 250,
  parameter int unsigned ROWS          = 2048,
  parameter int unsigned RETAIN_US     = 32000,
  parameter int unsigned PAUSE_US      = 200,
  parameter int unsigned WAKE_N        = 8,
  parameter int unsigned MAX_OWED      = 4,
  parameter int unsigned CAS_SETUP_CYC = 2,
  parameter int unsigned CAS_HOLD_CYC  = 2,
  parameter int unsigned RAS_LOW_CYC   = 13,
  parameter int unsigned RAS_PRE_CYC   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_gnt,
  output logic bus_req,
  output logic ref_busy,
  output logic ras_n,
  output logic cas_n,
  output logic ready,
  output logic urgent
);
  localparam int unsigned TICK_CYC  = CLK_MHZ * RETAIN_US / ROWS;
  localparam int unsigned PAUSE_CYC = CLK_MHZ * PAUSE_US;
  localparam int unsigned WCW       = cnt_width(WAKE_N);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe_q;
  logic       rst_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_l = rst_pipe_q[1];

  ctl_st_e        st_q, st_d;
  logic [WCW-1:0] wcnt_q, wcnt_d;
  logic           wcnt_en;
  logic           miss_q, miss_d;
  logic           pause_tick, due_tick;
  logic           seq_start, seq_idle, seq_done;
  logic           owed_full, owed_any, owed_ovf, owed_clr, owed_dec;
  logic           wake_last, in_service;

  assign in_service = (st_q == CT_IDLE) || (st_q == CT_REF);
  assign ready      = in_service && !miss_q;
  assign ref_busy   = (st_q == CT_WAKE) || (st_q == CT_REF);
  assign bus_req    = (st_q == CT_WREQ) || ref_busy ||
                      ((st_q == CT_IDLE) && owed_any && !miss_q);
  assign urgent     = owed_full;
  assign wake_last  = (wcnt_q == WCW'(WAKE_N - 1));
  assign seq_start  = ref_busy && seq_idle;
  assign owed_dec   = (st_q == CT_REF) && seq_done;
  assign owed_clr   = (st_q == CT_WAKE) && seq_done && wake_last;

  rfsh_tick_timer #(.PERIOD(PAUSE_CYC)) i_pause_timer (
    .clk  (clk),
    .rst_n(rst_l),
    .run  (st_q == CT_PAUSE),
    .tick (pause_tick)
  );

  rfsh_tick_timer #(.PERIOD(TICK_CYC)) i_due_timer (
    .clk  (clk),
    .rst_n(rst_l),
    .run  (ready),
    .tick (due_tick)
  );

  rfsh_owed_counter #(.MAX_OWED(MAX_OWED)) i_owed (
    .clk     (clk),
    .rst_n   (rst_l),
    .inc     (due_tick),
    .dec     (owed_dec),
    .clr     (owed_clr),
    .full    (owed_full),
    .nonzero (owed_any),
    .overflow(owed_ovf)
  );

  cbr_strobe_seq #(
    .SETUP_CYC(CAS_SETUP_CYC),
    .HOLD_CYC (CAS_HOLD_CYC),
    .LOW_CYC  (RAS_LOW_CYC),
    .PRE_CYC  (RAS_PRE_CYC)
  ) i_seq (
    .clk  (clk),
    .rst_n(rst_l),
    .start(seq_start),
    .idle (seq_idle),
    .done (seq_done),
    .ras_n(ras_n),
    .cas_n(cas_n)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      CT_PAUSE: if (pause_tick) st_d = CT_WREQ;
      CT_WREQ:  if (bus_gnt)    st_d = CT_WAKE;
      CT_WAKE:  if (seq_done && wake_last) st_d = CT_IDLE;
      CT_IDLE: begin
        if (miss_q)                   st_d = CT_WREQ;
        else if (owed_any && bus_gnt) st_d = CT_REF;
      end
      CT_REF:   if (seq_done) st_d = CT_IDLE;
      default:  st_d = CT_PAUSE;
    endcase
  end

  always_comb begin
    wcnt_d  = wcnt_q;
    wcnt_en = 1'b0;
    if (st_q == CT_WREQ) begin
      wcnt_d  = '0;
      wcnt_en = 1'b1;
    end else if ((st_q == CT_WAKE) && seq_done) begin
      wcnt_d  = wcnt_q + 1'b1;
      wcnt_en = 1'b1;
    end
  end

  always_comb begin
    miss_d = miss_q;
    if (owed_clr)      miss_d = 1'b0;
    else if (owed_ovf) miss_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      st_q   <= CT_PAUSE;
      wcnt_q <= '0;
      miss_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      miss_q <= miss_d;
      if (wcnt_en) wcnt_q <= wcnt_d;
    end
  end
endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk #(
  parameter int unsigned LOW_MIN = 13
) (
  input logic clk,
  input logic rst_n,
  input logic bus_gnt,
  input logic bus_req,
  input logic ref_busy,
  input logic ras_n,
  input logic cas_n,
  input logic ready,
  input logic urgent
);
  logic [15:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              low_run <= '0;
    else if (ras_n)          low_run <= '0;
    else if (low_run != '1)  low_run <= low_run + 1'b1;
  end

  // R4
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && !$past(cas_n)));

  // R5
  ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (low_run >= 16'(LOW_MIN)));

  // R6
  strobe_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n) |-> ref_busy);

  // R6
  grant_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_busy) |-> ($past(bus_gnt) && $past(bus_req)));

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_busy |-> bus_req);

  // R8
  urgent_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (urgent && ready) |-> bus_req);

  // R3
  ready_after_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(ref_busy));
endmodule

bind dram_refresh_sched rfsh_sched_chk #(.LOW_MIN(RAS_LOW_CYC)) i_rfsh_sched_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_gnt (bus_gnt),
  .bus_req (bus_req),
  .ref_busy(ref_busy),
  .ras_n   (ras_n),
  .cas_n   (cas_n),
  .ready   (ready),
  .urgent  (urgent)
);

// File: tb/test_dram_refresh_sched.sv
`timescale 1ns/1ps
module test_dram_refresh_sched;
  localparam int unsigned P_MHZ   = 4;
  localparam int unsigned P_ROWS  = 16;
  localparam int unsigned P_RET   = 512;
  localparam int unsigned P_PAUSE = 20;
  localparam int unsigned P_WAKE  = 8;
  localparam int unsigned P_MAX   = 3;
  localparam int unsigned P_CSU   = 2;
  localparam int unsigned P_HOLD  = 2;
  localparam int unsigned P_LOW   = 6;
  localparam int unsigned P_PRE   = 4;

  function automatic int exp_interval();
    return P_MHZ * P_RET / P_ROWS;
  endfunction

  function automatic int exp_pause();
    return P_MHZ * P_PAUSE;
  endfunction

  logic clk = 1'b0;
  logic rst_n;
  logic bus_gnt;
  logic bus_req, ref_busy, ras_n, cas_n, ready, urgent;

  always #2 clk = ~clk;

  dram_refresh_sched #(
    .CLK_MHZ(P_MHZ), .ROWS(P_ROWS), .RETAIN_US(P_RET), .PAUSE_US(P_PAUSE),
    .WAKE_N(P_WAKE), .MAX_OWED(P_MAX), .CAS_SETUP_CYC(P_CSU),
    .CAS_HOLD_CYC(P_HOLD), .RAS_LOW_CYC(P_LOW), .RAS_PRE_CYC(P_PRE)
  ) i_dram_refresh_sched (
    .clk(clk), .rst_n(rst_n), .bus_gnt(bus_gnt), .bus_req(bus_req),
    .ref_busy(ref_busy), .ras_n(ras_n), .cas_n(cas_n), .ready(ready),
    .urgent(urgent)
  );

  int vectors = 0;
  int miscompares = 0;
  int falls = 0;
  bit mon_en = 0;
  bit gnt_en = 1;
  int dmax = 3;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Grant model: after a random delay, answer a raised request; drop with it.
  initial begin
    int dly;
    void'($urandom(32'h1d2e3f));
    bus_gnt = 1'b0;
    dly = 0;
    forever begin
      @(posedge clk); #1;
      if (!bus_req) begin
        bus_gnt = 1'b0;
        dly = $urandom_range(dmax, 0);
      end else if (!gnt_en) begin
        bus_gnt = 1'b0;
      end else if (dly == 0) begin
        bus_gnt = 1'b1;
      end else begin
        dly--;
      end
    end
  end

  // Strobe shape and ownership monitor.
  int  cas_low_run = 0, ras_low_run = 0, ras_high_run = 1000;
  bit  pr = 1, pc = 1, pb = 0, pg = 0;
  always @(negedge clk) begin
    if (mon_en) begin
      if (pr && !ras_n) begin
        falls++;
        chk(!cas_n && cas_low_run >= P_CSU, "R4 cas setup", cas_low_run, P_CSU);
        chk(ras_high_run >= P_PRE, "R5 precharge", ras_high_run, P_PRE);
      end
      if (!pr && ras_n) begin
        chk(ras_low_run >= P_LOW, "R5 row low", ras_low_run, P_LOW);
        chk(pc, "R4 cas high before ras rises", pc, 1);
      end
      if (!pc && cas_n && !ras_n)
        chk(ras_low_run == P_HOLD, "R4 cas hold", ras_low_run, P_HOLD);
      if (!ras_n || !cas_n) chk(ref_busy, "R6 owner", ref_busy, 1);
      if (ref_busy) chk(bus_req, "R10 req held", bus_req, 1);
      if (ref_busy && !pb) chk(pg, "R6 grant first", pg, 1);
      cas_low_run  = cas_n ? 0 : cas_low_run + 1;
      ras_low_run  = ras_n ? 0 : ras_low_run + 1;
      ras_high_run = ras_n ? ras_high_run + 1 : 0;
      pr = ras_n; pc = cas_n; pb = ref_busy; pg = bus_gnt;
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog R3 actual=0 expected=1 (run did not finish)");
    summary();
  end

  initial begin
    int t, f0, lowcnt, iv;
    iv = exp_interval();
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1
    chk(ras_n && cas_n, "R1 strobes", {ras_n, cas_n}, 3);
    chk(!bus_req && !ref_busy, "R1 req/busy", {bus_req, ref_busy}, 0);
    chk(!ready && !urgent, "R1 ready/urgent", {ready, urgent}, 0);

    @(posedge clk); #1 rst_n = 1'b1; mon_en = 1;
    // R2
    t = 0;
    while (!bus_req && t < 1000) begin @(negedge clk); t++; end
    chk(t >= exp_pause() && t <= exp_pause() + 4, "R2 pause length", t, exp_pause());
    chk(falls == 0, "R2 no strobes in pause", falls, 0);

    // R3
    f0 = falls; t = 0;
    while (!ready && t < 2000) begin @(negedge clk); t++; end
    chk(ready, "R3 ready after wake", ready, 1);
    chk(falls - f0 == P_WAKE, "R3 wake count", falls - f0, P_WAKE);

    // R7
    f0 = falls; lowcnt = 0;
    repeat (10 * iv) begin @(negedge clk); if (!ready) lowcnt++; end
    chk((falls - f0) >= 9 && (falls - f0) <= 11, "R7 refresh rate", falls - f0, 10);
    chk(lowcnt == 0, "R7 ready held", lowcnt, 0);

    // R8
    gnt_en = 0; t = 0;
    while (!urgent && t < 5 * iv) begin @(negedge clk); t++; end
    chk(urgent, "R8 urgent at limit", urgent, 1);
    chk(ready, "R8 still ready", ready, 1);
    f0 = falls; gnt_en = 1; t = 0;
    @(negedge clk);
    while (bus_req && t < iv) begin @(negedge clk); t++; end
    chk(falls - f0 == P_MAX, "R8 owed refreshes run", falls - f0, P_MAX);
    chk(!urgent, "R8 urgent cleared", urgent, 0);

    // R9
    gnt_en = 0; t = 0;
    while (!urgent && t < 5 * iv) begin @(negedge clk); t++; end
    t = 0;
    while (ready && t < 2 * iv) begin @(negedge clk); t++; end
    chk(!ready, "R9 ready dropped on miss", ready, 0);
    repeat (20) @(negedge clk);
    chk(!ready && ras_n && cas_n, "R9 idle while denied", {ready, ras_n, cas_n}, 3);
    f0 = falls; gnt_en = 1; t = 0;
    while (!ready && t < 2000) begin @(negedge clk); t++; end
    chk(falls - f0 == P_WAKE, "R9 re-wake count", falls - f0, P_WAKE);
    chk(ready && !urgent, "R9 recovered", {ready, urgent}, 2);

    // Due point landing on the end of an in-flight strobe cycle (R8/R9).
    for (int off = 0; off < 4; off++) begin
      gnt_en = 0; dmax = 0; t = 0;
      while (!urgent && t < 5 * iv) begin @(negedge clk); t++; end
      repeat (iv - 18 + 3 * off) @(negedge clk);
      gnt_en = 1; t = 0;
      @(negedge clk);
      while (!(ready && !bus_req && !urgent) && t < 4 * iv) begin @(negedge clk); t++; end
      chk(ready && !urgent && !bus_req, "R9 settle after coincidence", {ready, urgent, bus_req}, 4);
    end

    // Random grant latency (R7).
    for (int k = 0; k < 30; k++) begin
      dmax = $urandom_range(20, 0);
      lowcnt = 0;
      repeat (2 * iv) begin @(negedge clk); if (!ready) lowcnt++; end
      chk(lowcnt == 0, "R7 ready under random latency", lowcnt, 0);
    end

    summary();
  end
endmodule